// File: doc/BRIEF.md
# Write-Triggered FIFO Activity Status Generator

This block turns single-cycle write strobes from a bus into a read-only status word with three activity flags. The flags mimic a short transfer path draining one stage at a time. A write raises the input-stage flag at once. The middle-stage flag rises a fixed number of ticks later. The output-stage flag rises later again. Each flag then stays high for its own fixed span.

Each flag is driven by a pair of deadline timers. These are compared against a free-running tick counter that advances once per clock. When writes arrive close together, the flags stay high longer, but their rising edges do not move. A timer that has fired disarms itself. The next write that finds it disarmed schedules it again, counting from that write.

The status word is combinational. In any cycle it shows the flags as evaluated in that same cycle, including the effect of a write in that cycle. A read can therefore sample `status_o` directly.

Top module: `fifo_wr_status`

## Requirements
- R1: In the cycle where `wr_i` is high and the input flag's clear timer is idle, `status_o[5]` reads 1. It then reads 0 from 60 cycles after that write onward, unless another write extends it.
- R2: A write that finds the bit-5 clear timer armed adds 60 cycles to its pending clear time instead of restarting it. A burst of n back-to-back writes holds bit 5 high for 60·n cycles.
- R3: A write schedules `status_o[4]` to rise 60 cycles after the write, but only when no bit-4 rise is pending. A pending rise time is never moved by later writes.
- R4: When no bit-4 fall is pending, bit 4 is scheduled to fall 160 cycles after its (new or still pending) rise time. Otherwise the pending fall time is extended by 160 cycles.
- R5: `status_o[0]` rises 120 cycles after a write when no bit-0 rise is pending. It falls 420 cycles after that rise, or its pending fall is extended by 420 cycles.
- R6: A write in the very cycle a fall comes due counts the fall as still pending. The flag is extended and does not drop in that cycle.
- R7: A timer that has fired returns to idle. The next write schedules it afresh relative to that write, so two writes further apart than a flag's total span produce two separate pulses on that flag.
- R8: Reset (`rst_ni` low) disarms all five timers at once. It leaves the three flags at the values they held, both during reset and after release until a later write. Writes during reset have no effect.
- R9: Every bit of `status_o` other than 5, 4 and 0 reads as 0.
- R10: After power-up and reset, with no write yet, `status_o` reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the tick counter advances once per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the timers and the tick counter |
| wr_i | input | 1 | Write strobe from the bus side, one cycle per write |
| status_o | output | 32 | Status word: bit 5 input stage, bit 4 middle stage, bit 0 output stage, all other bits 0 |

## Verification
The interesting collision is a write that lands in exactly the cycle in which one of the flag timers comes due. That timer may be a falling deadline that the write must extend, or a pending rise that must fire while being left in place. The bench provokes this by sweeping the gap between two writes across each flag's due cycle, one cycle before and one cycle after. The gap list includes 60, 220 and 540. It judges every cycle of the resulting waveforms against pulse windows computed in closed form from the gap, the delay and the hold span. At a coincident gap, the flag must show one unbroken pulse. One cycle later, it must show a one-cycle dip or two separate pulses.

// File: rtl/fst_pkg.sv
package fst_pkg;

   // timer slots; the numbering fixes which falls follow which rises
   localparam int NUM_TMR  = 5;
   localparam int TMR_A_OFF = 0;
   localparam int TMR_B_ON  = 1;
   localparam int TMR_B_OFF = 2;
   localparam int TMR_C_ON  = 3;
   localparam int TMR_C_OFF = 4;

   // how a write treats a timer that is already armed
   typedef enum logic {
      SCHED_HOLD   = 1'b0,   // keep the pending deadline untouched
      SCHED_EXTEND = 1'b1    // push the pending deadline out by its span
   } sched_mode_e;

   function automatic sched_mode_e slot_mode(input int id);
      return (id == TMR_B_ON || id == TMR_C_ON) ? SCHED_HOLD : SCHED_EXTEND;
   endfunction

   // a fall slot bases its fresh deadline on the rise slot before it
   function automatic bit slot_chained(input int id);
      return (id == TMR_B_OFF || id == TMR_C_OFF);
   endfunction

endpackage

// File: rtl/fst_tick_ctr.sv
module fst_tick_ctr #(
   parameter int TICK_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   output logic [TICK_W-1:0] tick_o
);

   logic [TICK_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + TICK_W'(1);
      end
   end

   assign tick_o = cnt_q;

endmodule

// File: rtl/fst_timer.sv
module fst_timer
   import fst_pkg::*;
#(
   parameter int          TICK_W = 16,
   parameter int          DELTA  = 60,
   parameter sched_mode_e MODE   = SCHED_EXTEND
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [TICK_W-1:0] tick_i,
   input  logic              wr_i,
   input  logic [TICK_W-1:0] base_i,
   output logic              fire_o,
   output logic              armed_o,
   output logic [TICK_W-1:0] dl_o,
   output logic [TICK_W-1:0] sched_o
);

   localparam logic [TICK_W-1:0] STEP = TICK_W'(DELTA);

   logic              armed_q, armed_d;
   logic [TICK_W-1:0] dl_q, dl_d;
   logic              due;

   // a deadline equal to the current tick is both due and still pending
   assign due = armed_q && (dl_q == tick_i);

   generate
      if (MODE == SCHED_EXTEND) begin : g_extend
         always_comb begin
            sched_o = armed_q ? (dl_q + STEP) : (base_i + STEP);
            fire_o  = due && !wr_i;
            armed_d = armed_q;
            dl_d    = dl_q;
            if (wr_i) begin
               armed_d = 1'b1;
               dl_d    = sched_o;
            end else if (due) begin
               armed_d = 1'b0;
            end
         end
      end else begin : g_hold
         always_comb begin
            sched_o = armed_q ? dl_q : (base_i + STEP);
            fire_o  = due;
            armed_d = armed_q;
            dl_d    = dl_q;
            if (wr_i && !armed_q) begin
               armed_d = 1'b1;
               dl_d    = sched_o;
            end else if (due) begin
               armed_d = 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         dl_q    <= '0;
      end else begin
         armed_q <= armed_d;
         dl_q    <= dl_d;
      end
   end

   assign armed_o = armed_q;
   assign dl_o    = dl_q;

endmodule

// File: rtl/fst_flag.sv
module fst_flag #(
   parameter bit INIT = 1'b0
) (
   input  logic clk_i,
   input  logic run_i,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o,
   output logic next_o
);

   // no reset: the flag keeps its value through a timer reset
   logic q_q = INIT;

   // set first, clear after it, so a coincident clear wins
   always_comb begin
      next_o = q_q;
      if (run_i) begin
         if (set_i) next_o = 1'b1;
         if (clr_i) next_o = 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      q_q <= next_o;
   end

   assign q_o = q_q;

endmodule

// File: rtl/fifo_wr_status.sv
module fifo_wr_status
   import fst_pkg::*;
#(
   parameter int         TICK_W    = 16,
   parameter int         STATUS_W  = 32,
   parameter int         POS_A     = 5,
   parameter int         POS_B     = 4,
   parameter int         POS_C     = 0,
   parameter int         A_HOLD    = 60,
   parameter int         B_DELAY   = 60,
   parameter int         B_HOLD    = 160,
   parameter int         C_DELAY   = 120,
   parameter int         C_HOLD    = 420,
   parameter logic [2:0] FLAG_INIT = 3'b000   // {c, b, a}
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_i,
   output logic [STATUS_W-1:0] status_o
);

   localparam int SPAN_MAX = C_DELAY + C_HOLD;
   localparam int DELTA_TAB [NUM_TMR] = '{A_HOLD, B_DELAY, B_HOLD, C_DELAY, C_HOLD};

   // elaboration-time parameter checks
   generate
      if (TICK_W < 4 || TICK_W > 32) begin : g_bad_tick
         $error("TICK_W out of range");
      end
      if ((64'd1 << TICK_W) <= 64'(2 * SPAN_MAX)) begin : g_bad_span
         $error("TICK_W too narrow for the scheduled spans");
      end
      if (POS_A >= STATUS_W || POS_B >= STATUS_W || POS_C >= STATUS_W) begin : g_bad_pos
         $error("flag position outside status word");
      end
      if (POS_A == POS_B || POS_A == POS_C || POS_B == POS_C) begin : g_dup_pos
         $error("flag positions must differ");
      end
      if (A_HOLD < 1 || B_DELAY < 1 || B_HOLD < 1 || C_DELAY < 1 || C_HOLD < 1) begin : g_bad_delta
         $error("all delays and spans must be at least one tick");
      end
   endgenerate

   logic [TICK_W-1:0] tick_w;
   logic [NUM_TMR-1:0] t_fire;
   logic [NUM_TMR-1:0] t_armed;
   logic [TICK_W-1:0]  t_dl    [NUM_TMR];
   logic [TICK_W-1:0]  t_sched [NUM_TMR];
   logic [TICK_W-1:0]  t_base  [NUM_TMR];

   fst_tick_ctr #(
      .TICK_W (TICK_W)
   ) tick_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick_w)
   );

   generate
      for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
         if (slot_chained(i)) begin : g_chain
            assign t_base[i] = t_sched[i-1];
         end else begin : g_free
            assign t_base[i] = tick_w;
         end

         fst_timer #(
            .TICK_W (TICK_W),
            .DELTA  (DELTA_TAB[i]),
            .MODE   (slot_mode(i))
         ) tmr_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .tick_i  (tick_w),
            .wr_i    (wr_i),
            .base_i  (t_base[i]),
            .fire_o  (t_fire[i]),
            .armed_o (t_armed[i]),
            .dl_o    (t_dl[i]),
            .sched_o (t_sched[i])
         );
      end
   endgenerate

   logic [2:0] flags_q;
   logic [2:0] flags_n;
   logic [2:0] f_set;
   logic [2:0] f_clr;

   // index 0 = input stage, 1 = middle stage, 2 = output stage
   assign f_set = {t_fire[TMR_C_ON],  t_fire[TMR_B_ON],  wr_i};
   assign f_clr = {t_fire[TMR_C_OFF], t_fire[TMR_B_OFF], t_fire[TMR_A_OFF]};

   generate
      for (genvar f = 0; f < 3; f++) begin : g_flag
         fst_flag #(
            .INIT (FLAG_INIT[f])
         ) flag_i (
            .clk_i  (clk_i),
            .run_i  (rst_ni),
            .set_i  (f_set[f]),
            .clr_i  (f_clr[f]),
            .q_o    (flags_q[f]),
            .next_o (flags_n[f])
         );
      end
   endgenerate

   always_comb begin
      status_o        = '0;
      status_o[POS_A] = flags_n[0];
      status_o[POS_B] = flags_n[1];
      status_o[POS_C] = flags_n[2];
   end

endmodule

// File: rtl/fifo_wr_status_chk.sv
module fifo_wr_status_chk #(
   parameter int TICK_W   = 16,
   parameter int STATUS_W = 32,
   parameter int POS_A    = 5,
   parameter int POS_B    = 4,
   parameter int POS_C    = 0,
   parameter int B_DELAY  = 60,
   parameter int C_DELAY  = 120
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                wr_i,
   input logic [STATUS_W-1:0] status_o,
   input logic [4:0]          armed_i,
   input logic [TICK_W-1:0]   tick_i,
   input logic [TICK_W-1:0]   b_rise_dl_i,
   input logic [TICK_W-1:0]   b_fall_dl_i,
   input logic [TICK_W-1:0]   c_rise_dl_i,
   input logic [2:0]          flags_i
);

   logic [STATUS_W-1:0] used_mask;
   always_comb begin
      used_mask        = '0;
      used_mask[POS_A] = 1'b1;
      used_mask[POS_B] = 1'b1;
      used_mask[POS_C] = 1'b1;
   end

   AST_WRITE_RAISES_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |-> status_o[POS_A]); // R1

   AST_B_RISE_WITHIN_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_i[1] |-> ((b_rise_dl_i - tick_i) <= TICK_W'(B_DELAY))); // R3

   AST_B_FALL_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_i[1] && armed_i[2]) |-> ((b_fall_dl_i - tick_i) > (b_rise_dl_i - tick_i))); // R4

   AST_C_RISE_WITHIN_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_i[3] |-> ((c_rise_dl_i - tick_i) <= TICK_W'(C_DELAY))); // R5

   AST_RESET_DISARMS: assert property (@(posedge clk_i)
      !rst_ni |=> (armed_i == 5'b0)); // R8

   AST_FLAGS_FROZEN_IN_RESET: assert property (@(posedge clk_i)
      !rst_ni |=> $stable(flags_i)); // R8

   AST_UNUSED_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o & ~used_mask) == '0); // R9

endmodule

bind fifo_wr_status fifo_wr_status_chk #(
   .TICK_W   (TICK_W),
   .STATUS_W (STATUS_W),
   .POS_A    (POS_A),
   .POS_B    (POS_B),
   .POS_C    (POS_C),
   .B_DELAY  (B_DELAY),
   .C_DELAY  (C_DELAY)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .wr_i        (wr_i),
   .status_o    (status_o),
   .armed_i     (t_armed),
   .tick_i      (tick_w),
   .b_rise_dl_i (t_dl[1]),
   .b_fall_dl_i (t_dl[2]),
   .c_rise_dl_i (t_dl[3]),
   .flags_i     (flags_q)
);

// File: tb/fifo_wr_status_tb_top.sv
module fifo_wr_status_tb_top;

   localparam int D_A = 0,   H_A = 60;
   localparam int D_B = 60,  H_B = 160;
   localparam int D_C = 120, H_C = 420;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [31:0] status;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   fifo_wr_status dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .wr_i     (wr),
      .status_o (status)
   );

   task automatic chk_bit(input string req, input int cyc, input int pos,
                          input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: cycle %0d bit %0d got %0b expected %0b", req, cyc, pos, got, exp);
      end
   endtask

   task automatic chk_word(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: status got %08h expected %08h", req, got, exp);
      end
   endtask

   // pulse window for one flag after two writes gap cycles apart (gap<=0: single write)
   function automatic bit win2(input int k, input int gap, input int d, input int h);
      if (gap <= 0) return (k >= d) && (k < d + h);
      if (gap <= d + h) return (k >= d) && (k < d + 2 * h);   // fall still pending: R6
      return ((k >= d) && (k < d + h)) || ((k >= gap + d) && (k < gap + d + h));
   endfunction

   // pulse window after n writes on consecutive cycles
   function automatic bit winb(input int k, input int n, input int d, input int h);
      return (k >= d) && (k < d + n * h);
   endfunction

   task automatic step_cycle(input logic w);
      @(posedge clk);
      #1 wr = w;
      @(negedge clk);
   endtask

   task automatic check_cycle(input int k, input bit ea, input bit eb, input bit ec,
                              input string ra, input string rb, input string rc);
      chk_bit(ra, k, 5, status[5], ea);
      chk_bit(rb, k, 4, status[4], eb);
      chk_bit(rc, k, 0, status[0], ec);
      chk_word("R9", status & ~32'h0000_0031, 32'h0);
   endtask

   task automatic run_two(input int gap);
      int len;
      string ra, rb, rc;
      len = (gap > 0 ? gap : 0) + 1000;
      ra = (gap > 0 && gap > H_A) ? "R7 R1" : (gap > 0 ? "R2 R6" : "R1");
      rb = (gap > 0 && gap > D_B + H_B) ? "R7 R3 R4" : "R3 R4 R6";
      rc = (gap > 0 && gap > D_C + H_C) ? "R7 R5" : "R5 R6";
      for (int k = 0; k < len; k++) begin
         step_cycle((k == 0) || (gap > 0 && k == gap));
         check_cycle(k, win2(k, gap, D_A, H_A), win2(k, gap, D_B, H_B),
                     win2(k, gap, D_C, H_C), ra, rb, rc);
      end
   endtask

   task automatic run_burst(input int n);
      for (int k = 0; k < n * H_C + 200; k++) begin
         step_cycle(k < n);
         check_cycle(k, winb(k, n, D_A, H_A), winb(k, n, D_B, H_B),
                     winb(k, n, D_C, H_C), "R2", "R4 R3", "R5");
      end
   endtask

   initial begin
      int gaps [14] = '{1, 30, 59, 60, 61, 100, 219, 220, 221, 400, 539, 540, 541, 700};
      // R10: reset and idle state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_word("R10", status, 32'h0);
      #1 rst_n = 1'b1;
      repeat (5) step_cycle(1'b0);
      chk_word("R10", status, 32'h0);

      // single write, then two writes over a sweep of gaps
      run_two(0);
      foreach (gaps[i]) run_two(gaps[i]);

      // back-to-back bursts
      for (int n = 1; n <= 4; n++) run_burst(n);

      // R8: reset in the middle of activity freezes the flags
      for (int k = 0; k < 130; k++) step_cycle(k == 0);
      @(posedge clk);
      #1 begin rst_n = 1'b0; wr = 1'b1; end
      @(negedge clk);
      chk_word("R8", status, 32'h0000_0011);
      for (int k = 0; k < 4; k++) begin
         step_cycle(1'b1);
         chk_word("R8", status, 32'h0000_0011);
      end
      @(posedge clk);
      #1 begin rst_n = 1'b1; wr = 1'b0; end
      for (int k = 0; k < 1200; k++) begin
         step_cycle(1'b0);
         if (k % 100 == 0) chk_word("R8", status, 32'h0000_0011);
      end
      chk_word("R8", status, 32'h0000_0011);

      // R7: fresh scheduling after the disarm
      for (int k = 0; k < 700; k++) begin
         step_cycle(k == 0);
         if (k == 0)   chk_word("R7", status, 32'h0000_0031);
         if (k == 100) chk_word("R7", status, 32'h0000_0011);
         if (k == 300) chk_word("R7", status, 32'h0000_0001);
         if (k == 600) chk_word("R7", status, 32'h0000_0000);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule